// File: doc/BRIEF.md
# Edge-Triggered DMA Block Request Sequencer

This block is the request and sequencing part of one DMA channel whose transfers are paced by an external active-low request pin in falling-edge mode. It samples the pin on every clock, through a two-flop synchronizer. Each accepted falling edge starts exactly one block: a number of source-read / destination-write bus-cycle pairs, then one dead cycle, then a bus release of at least two cycles. Address generation, data movement and arbitration between masters are left to the surrounding logic. This block only issues the phase strobes and the bus request.

Software enables the channel with a write strobe that carries the enable bit, the block size and the total number of blocks. Once a request is latched, acceptance closes. It reopens only after the pin has been seen high since activation and the dead cycle of the running block has finished. A pin held low therefore never starts a second block. When the block count runs out, a transfer-end flag rises and the channel disables itself. Clearing the enable bit stops acceptance at once. Any block already running is completed.

Top module: `dma_edge_req_seq`

## Requirements
- R1: After reset, busReq, rdPhase, wrPhase, deadPhase and xferEnd are all 0.
- R2: While the channel is disabled, a low level on reqN starts no block and raises no bus request.
- R3: With acceptance open, if reqN is driven low just after a falling clock edge, busReq rises after the 4th following rising edge (2 synchronizer stages, 1 request latch, 1 activation).
- R4: After activation, busReq stays high and no read phase is issued until busGrant is sampled high. The first rdPhase follows the rising edge at which busGrant is 1.
- R5: A block consists of blkSize pairs (1 to 255), each a one-cycle rdPhase followed by a one-cycle wrPhase, and then exactly one deadPhase cycle. At most one phase output is high in any cycle.
- R6: In the two cycles that follow deadPhase, busReq and all phase outputs are 0.
- R7: reqN held low without interruption yields exactly one block.
- R8: If reqN goes high and then low again while a block is running, and is low when the dead cycle ends, exactly one further block follows.
- R9: If reqN has not been seen high by the end of the dead cycle, acceptance opens once a high level is sampled. A later falling edge then starts a block.
- R10: The dead cycle of block number blkCount sets xferEnd to 1 in the next cycle. After that, no further edge starts a block. A new enabling write clears xferEnd.
- R11: A write with enData=0 during a block lets that block finish. No later block starts on any edge.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rstN | input | 1 | Active-low asynchronous reset |
| reqN | input | 1 | Active-low external transfer request pin (asynchronous) |
| enWrite | input | 1 | One-cycle strobe: the control register is written |
| enData | input | 1 | Enable bit value carried by the write |
| blkSize | input | 8 | Read/write pairs per block, loaded on enabling |
| blkCount | input | 16 | Total number of blocks, loaded on enabling |
| busGrant | input | 1 | Bus granted to this channel |
| busReq | output | 1 | Bus requested; high from activation through the dead cycle |
| rdPhase | output | 1 | Source read cycle in progress |
| wrPhase | output | 1 | Destination write cycle in progress |
| deadPhase | output | 1 | DMA dead cycle in progress |
| xferEnd | output | 1 | Transfer count exhausted |

## Verification
A wrong arming state shows as an extra block, or a missing one, on the phase outputs. The bench therefore compares every phase cycle against a queue of expected phases, and any phase that was not predicted is reported in the cycle it appears. A stuck request latch or a wrong synchronizer depth moves the rise of busReq, which is checked on its exact cycle. A wrong block counter shows as xferEnd missing, or a block starting after the end, within one block time.

// File: rtl/dreq_pkg.sv
package dreq_pkg;
  typedef enum logic [2:0] {
    S_IDLE, S_WAIT, S_READ, S_WRITE, S_DEAD, S_REL1, S_REL2
  } seqState_t;

  typedef struct packed {
    logic activate;  // request taken, block begins
    logic beatDone;  // one read/write pair finished
    logic blockEnd;  // dead cycle in progress
  } seqStrobe_t;
endpackage

// File: rtl/dreq_dpath.sv
module dreq_dpath
  import dreq_pkg::*;
#(
  parameter int SZW = 8,
  parameter int CW  = 16
) (
  input  logic           clk,
  input  logic           rstN,
  input  logic           reqN,
  input  logic           enWrite,
  input  logic           enData,
  input  logic [SZW-1:0] blkSize,
  input  logic [CW-1:0]  blkCount,
  input  seqStrobe_t     stb,
  output logic           startOk,
  output logic           lastBeat,
  output logic           xferEnd
);
  localparam int SYNC_STAGES = 2;

  logic [SYNC_STAGES-1:0] syncChain;
  logic pinHigh;
  logic enabled, accOpen, pending, seenHigh, deadDone;
  logic [CW-1:0]  remBlocks;
  logic [SZW-1:0] sizeReg, beatCnt;

  always_ff @(posedge clk or negedge rstN) begin
    if (!rstN) syncChain <= '1;
    else       syncChain <= {syncChain[SYNC_STAGES-2:0], reqN};
  end
  assign pinHigh = syncChain[SYNC_STAGES-1];

  always_ff @(posedge clk or negedge rstN) begin
    if (!rstN) begin
      enabled   <= 1'b0;
      accOpen   <= 1'b0;
      pending   <= 1'b0;
      seenHigh  <= 1'b0;
      deadDone  <= 1'b0;
      xferEnd   <= 1'b0;
      remBlocks <= '0;
      sizeReg   <= '0;
    end else if (enWrite) begin
      pending <= 1'b0;
      if (enData) begin
        enabled   <= 1'b1;
        accOpen   <= 1'b1;
        seenHigh  <= 1'b0;
        deadDone  <= 1'b0;
        xferEnd   <= 1'b0;
        remBlocks <= blkCount;
        sizeReg   <= blkSize;
      end else begin
        enabled <= 1'b0;
        accOpen <= 1'b0;
      end
    end else if (stb.activate) begin
      pending  <= 1'b0;
      accOpen  <= 1'b0;
      seenHigh <= 1'b0;
      deadDone <= 1'b0;
    end else begin
      if (pinHigh) seenHigh <= 1'b1;
      if (accOpen && !pinHigh) pending <= 1'b1;
      if (stb.blockEnd) begin
        remBlocks <= remBlocks - 1'b1;
        if (remBlocks == 1) begin
          xferEnd <= 1'b1;
          enabled <= 1'b0;
          accOpen <= 1'b0;
          pending <= 1'b0;
        end else if (enabled) begin
          if (seenHigh || pinHigh) accOpen  <= 1'b1;
          else                     deadDone <= 1'b1;
        end
      end else if (deadDone && pinHigh && enabled) begin
        accOpen  <= 1'b1;
        deadDone <= 1'b0;
      end
    end
  end

  always_ff @(posedge clk or negedge rstN) begin
    if (!rstN)             beatCnt <= '0;
    else if (stb.activate) beatCnt <= '0;
    else if (stb.beatDone) beatCnt <= beatCnt + 1'b1;
  end

  assign startOk  = pending && enabled && (remBlocks != '0);
  assign lastBeat = (beatCnt == sizeReg - 1'b1);

  a_r7_accept_closes: assert property (@(posedge clk) disable iff (!rstN)
    stb.activate && !enWrite |=> !accOpen && !pending);
  a_r2_no_pending_disabled: assert property (@(posedge clk) disable iff (!rstN)
    !enabled |-> !pending);
  a_r10_closed_after_end: assert property (@(posedge clk) disable iff (!rstN)
    xferEnd |-> !accOpen);
  a_r9_reopen_needs_high: assert property (@(posedge clk) disable iff (!rstN)
    $rose(accOpen) && !$past(enWrite) |-> $past(seenHigh || pinHigh));
endmodule

// File: rtl/dreq_ctrl.sv
module dreq_ctrl
  import dreq_pkg::*;
(
  input  logic       clk,
  input  logic       rstN,
  input  logic       startOk,
  input  logic       lastBeat,
  input  logic       busGrant,
  output seqStrobe_t stb,
  output logic       busReq,
  output logic       rdPhase,
  output logic       wrPhase,
  output logic       deadPhase
);
  seqState_t state, nextState;

  always_ff @(posedge clk or negedge rstN) begin
    if (!rstN) state <= S_IDLE;
    else       state <= nextState;
  end

  always_comb begin
    nextState = state;
    unique case (state)
      S_IDLE:  if (startOk) nextState = S_WAIT;
      S_WAIT:  if (busGrant) nextState = S_READ;
      S_READ:  nextState = S_WRITE;
      S_WRITE: nextState = lastBeat ? S_DEAD : S_READ;
      S_DEAD:  nextState = S_REL1;
      S_REL1:  nextState = S_REL2;
      S_REL2:  nextState = S_IDLE;
      default: nextState = S_IDLE;
    endcase
  end

  always_comb begin
    stb.activate = (state == S_IDLE) && startOk;
    stb.beatDone = (state == S_WRITE);
    stb.blockEnd = (state == S_DEAD);
  end

  assign rdPhase   = (state == S_READ);
  assign wrPhase   = (state == S_WRITE);
  assign deadPhase = (state == S_DEAD);
  assign busReq    = (state == S_WAIT) || rdPhase || wrPhase || deadPhase;

  a_r5_one_phase: assert property (@(posedge clk) disable iff (!rstN)
    $onehot0({rdPhase, wrPhase, deadPhase}));
  a_r5_write_after_read: assert property (@(posedge clk) disable iff (!rstN)
    rdPhase |=> wrPhase);
  a_r4_hold_without_grant: assert property (@(posedge clk) disable iff (!rstN)
    busReq && !rdPhase && !wrPhase && !deadPhase && !busGrant |=> busReq && !rdPhase);
  a_r6_release_gap: assert property (@(posedge clk) disable iff (!rstN)
    deadPhase |=> !busReq ##1 (!busReq && !rdPhase));
endmodule

// File: rtl/dma_edge_req_seq.sv
module dma_edge_req_seq
  import dreq_pkg::*;
#(
  parameter int SZW = 8,
  parameter int CW  = 16
) (
  input  logic           clk,
  input  logic           rstN,
  input  logic           reqN,
  input  logic           enWrite,
  input  logic           enData,
  input  logic [SZW-1:0] blkSize,
  input  logic [CW-1:0]  blkCount,
  input  logic           busGrant,
  output logic           busReq,
  output logic           rdPhase,
  output logic           wrPhase,
  output logic           deadPhase,
  output logic           xferEnd
);
  seqStrobe_t stb;
  logic startOk, lastBeat;

  dreq_dpath #(.SZW(SZW), .CW(CW)) uDpath (
    .clk(clk), .rstN(rstN), .reqN(reqN), .enWrite(enWrite), .enData(enData),
    .blkSize(blkSize), .blkCount(blkCount), .stb(stb),
    .startOk(startOk), .lastBeat(lastBeat), .xferEnd(xferEnd)
  );

  dreq_ctrl uCtrl (
    .clk(clk), .rstN(rstN), .startOk(startOk), .lastBeat(lastBeat),
    .busGrant(busGrant), .stb(stb), .busReq(busReq), .rdPhase(rdPhase),
    .wrPhase(wrPhase), .deadPhase(deadPhase)
  );
endmodule

// File: tb/tb_dma_edge_req_seq.sv
module tb_dma_edge_req_seq;
  logic clk = 0, rstN = 0, reqN = 1, enWrite = 0, enData = 0, busGrant = 0;
  logic [7:0]  blkSize = 0;
  logic [15:0] blkCount = 0;
  logic busReq, rdPhase, wrPhase, deadPhase, xferEnd;

  int checks = 0, failures = 0, sinceDead = 100, blocksSeen = 0;
  int expQ[$];
  bit finished = 0;

  dma_edge_req_seq dut (.*);

  always #10 clk = ~clk;

  task automatic check(input bit ok, input string tag, input int act, input int exp);
    checks++;
    if (!ok) begin
      failures++;
      $display("FAIL %s actual=%0d expected=%0d", tag, act, exp);
    end
  endtask

  task automatic pushBlock(input int pairs);
    for (int i = 0; i < pairs; i++) begin expQ.push_back(1); expQ.push_back(2); end
    expQ.push_back(3);
  endtask

  task automatic cyc(input int n);
    repeat (n) @(negedge clk);
  endtask

  task automatic enable(input bit en, input int sz, input int cnt);
    @(negedge clk);
    enWrite = 1; enData = en; blkSize = 8'(sz); blkCount = 16'(cnt);
    @(negedge clk);
    enWrite = 0;
  endtask

  // Monitor: compares each phase cycle against the expected queue
  always @(negedge clk) if (rstN && !finished) begin
    int code;
    code = rdPhase ? 1 : wrPhase ? 2 : deadPhase ? 3 : 0;
    if (sinceDead == 1 || sinceDead == 2)
      check(!busReq && code == 0, "R6 release gap", int'(busReq), 0);
    if (code != 0) begin
      if (expQ.size() == 0) check(0, "R7/R11 unexpected phase", code, 0);
      else begin
        int e;
        e = expQ.pop_front();
        check(code == e, "R5 phase order", code, e);
      end
    end
    if (code == 3) begin sinceDead = 0; blocksSeen++; end
    else if (sinceDead < 100) sinceDead++;
  end

  initial begin
    repeat (100000) @(posedge clk);
    check(0, "watchdog", 0, 1);
    finished = 1;
    $display("TB_RESULT checks=%0d failures=%0d", checks, failures);
    $finish;
  end

  initial begin
    cyc(2);
    // R1 reset state
    check(!busReq && !rdPhase && !wrPhase && !deadPhase && !xferEnd, "R1 reset",
          int'({busReq, rdPhase, wrPhase, deadPhase, xferEnd}), 0);
    rstN = 1;
    cyc(2);
    // R2 low pin while disabled
    reqN = 0; cyc(10);
    check(!busReq, "R2 disabled ignores pin", int'(busReq), 0);
    reqN = 1; cyc(4);

    enable(1, 3, 3);
    cyc(2);
    // R3 latency: drive low just after a falling edge
    reqN = 0;
    cyc(3);
    check(!busReq, "R3 not before 4th edge", int'(busReq), 0);
    cyc(1);
    check(busReq, "R3 request after 4th edge", int'(busReq), 1);
    // R4 no read without grant
    cyc(5);
    check(busReq && !rdPhase, "R4 waits for grant", int'(rdPhase), 0);
    pushBlock(3);
    busGrant = 1;
    cyc(1);
    check(rdPhase, "R4 read after grant", int'(rdPhase), 1);
    // R7 pin held low: only one block
    cyc(30);
    check(blocksSeen == 1 && expQ.size() == 0, "R7 single block on held low", blocksSeen, 1);
    check(!busReq, "R7 idle while held low", int'(busReq), 0);
    // R9 release then new edge
    reqN = 1; cyc(4);
    pushBlock(3);
    reqN = 0;
    wait (rdPhase); @(negedge clk);
    // R8 toggle during block, low at dead end
    reqN = 1; cyc(3); reqN = 0;
    pushBlock(3);
    cyc(40);
    check(blocksSeen == 3, "R8 second edge during block", blocksSeen, 3);
    check(expQ.size() == 0, "R9 block after late high", expQ.size(), 0);
    // R10 count exhausted
    check(xferEnd, "R10 end flag", int'(xferEnd), 1);
    reqN = 1; cyc(4); reqN = 0; cyc(20);
    check(blocksSeen == 3 && !busReq, "R10 no block after end", blocksSeen, 3);
    reqN = 1; cyc(4);

    // R11 disable during a block
    enable(1, 1, 5);
    check(!xferEnd, "R10 cleared by enable", int'(xferEnd), 0);
    pushBlock(1);
    reqN = 0; cyc(12);
    check(blocksSeen == 4, "R5 single pair block", blocksSeen, 4);
    reqN = 1; cyc(4);
    pushBlock(1);
    reqN = 0;
    wait (rdPhase);
    enable(0, 1, 5);
    cyc(10);
    check(blocksSeen == 5 && expQ.size() == 0, "R11 running block completes", blocksSeen, 5);
    reqN = 1; cyc(4); reqN = 0; cyc(20);
    check(blocksSeen == 5 && !busReq, "R11 no block after disable", blocksSeen, 5);
    check(!xferEnd, "R11 count not exhausted", int'(xferEnd), 0);

    finished = 1;
    $display("TB_RESULT checks=%0d failures=%0d", checks, failures);
    $finish;
  end
endmodule